// File: doc/BRIEF.md
# Password-Guarded Watchdog Timer

The block supervises software by counting prescaled clock ticks in a counter that software must keep restarting. If the counter overflows while the watchdog is enabled, the block takes one of two actions, chosen by a mode bit. It either emits a one-cycle interrupt pulse, or it raises a system reset request that stays high for a fixed number of cycles.

All configuration goes through one 32-bit control word. Every write must carry an 8-bit key in bits 15:8. A write with the correct key loads the configuration and restarts the prescaler and the counter. A write with any other key changes nothing in the configuration and is treated at once as a watchdog violation.

Two read-only flags tell software why the last watchdog action happened. They survive the block's own reset request and are cleared only by the external reset, so software that comes back up after a watchdog reset can still read why it happened.

Top module: `wdg_guard`

## Requirements
- R1: After the external reset, `rd_data` reads 0, and `irq` and `rst_req` are low.
- R2: `rd_data` shows the tick-divider select in bits 2:0, enable in bit 3, mode in bit 4, the watchdog-cause flag in bit 5 and the bad-key flag in bit 6. Every other bit reads 0, including the key field 15:8.
- R3: A write whose bits 15:8 equal the key (default 0x47) loads bits 4:0 into the configuration and restarts both the prescaler and the counter from zero.
- R4: While enabled, a timeout occurs exactly 2^CNT_W × D cycles after the restarting write edge and then repeats with the same period. D is 2, 4, 8, 64, 128, 1024, 2048 or 4096 for select values 0 to 7.
- R5: While the enable bit is 0, no timeout occurs.
- R6: In interrupt mode (bit 4 = 0), an action drives `irq` high for exactly one cycle, starting in the cycle after the edge that triggers it.
- R7: In reset mode (bit 4 = 1), an action drives `rst_req` high for exactly RST_HOLD cycles, starting in the cycle after the triggering edge, and `irq` stays low.
- R8: A write with a wrong key leaves the configuration unchanged and fires the action of the current mode in the next cycle, whether or not the watchdog is enabled.
- R9: Every action sets the cause flag. A bad-key action sets the bad-key flag, and a timeout action clears it.
- R10: The flags hold their value while and after `rst_req` is asserted. Only `rst_n` clears them.
- R11: A correct-key write on the same edge as a counter overflow wins: no action fires, and a full new period starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset, active low, asynchronous assert |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value, key in bits 15:8 |
| rd_data | output | 32 | Control word read value with status flags |
| irq | output | 1 | One-cycle timeout interrupt |
| rst_req | output | 1 | System reset request, held RST_HOLD cycles |

## Verification
Two events can land on the same clock edge: a counter overflow, and a control write with either a correct or a wrong key. The bench knows the exact overflow edge from the period formula. It places a correct-key write on that edge and expects no pulse, followed by one full fresh period. A wrong-key write and a pending period are judged by the flags: the bad-key flag must be set after the violation and cleared by the next real timeout.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam int SEL_W   = 3;
  localparam int SHIFT_W = 4;
  localparam int PRE_W   = 12;  // enough for the largest divider (2^12)
  localparam int CFG_W   = 5;
  localparam int KEY_LSB = 8;
  localparam int KEY_W   = 8;

  // bit 4 mode, bit 3 enable, bits 2:0 divider select
  typedef struct packed {
    logic             mode;
    logic             en;
    logic [SEL_W-1:0] sel;
  } wdg_cfg_t;

  function automatic logic [SHIFT_W-1:0] div_shift(input logic [SEL_W-1:0] s);
    case (s)
      3'd0:    div_shift = 4'd1;
      3'd1:    div_shift = 4'd2;
      3'd2:    div_shift = 4'd3;
      3'd3:    div_shift = 4'd6;
      3'd4:    div_shift = 4'd7;
      3'd5:    div_shift = 4'd10;
      3'd6:    div_shift = 4'd11;
      default: div_shift = 4'd12;
    endcase
  endfunction

endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  logic [PRE_W-1:0] pre_q, pre_d, mask;

  always_comb begin
    mask   = (PRE_W'(1) << div_shift(sel_i)) - PRE_W'(1);
    tick_o = ((pre_q & mask) == mask);
    pre_d  = clr_i ? '0 : pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R4: divider is at least 2, so ticks never come back to back
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  input  logic tick_i,
  output logic ovf_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  always_comb begin
    step  = en_i & tick_i;
    ovf_o = step & (&cnt_q);
    if (clr_i)     cnt_d = '0;
    else if (step) cnt_d = cnt_q + CNT_W'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: a restart leaves the counter at zero
  a_r3_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  // R5: a disabled counter does not advance
  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wdg_access.sv
module wdg_access
  import wdg_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY    = 8'h47,
  parameter int               DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              timeout_i,
  output wdg_cfg_t          cfg_o,
  output logic              restart_o,
  output logic              fire_o,
  output logic              cause_o,
  output logic              pwfail_o
);

  wdg_cfg_t cfg_q, cfg_d;
  logic     cause_q, cause_d, pwfail_q, pwfail_d;
  logic     key_ok, good_wr, bad_wr;
  logic     unused_bits;

  assign unused_bits = ^{wr_data_i[DATA_W-1:KEY_LSB+KEY_W], wr_data_i[KEY_LSB-1:CFG_W]};

  always_comb begin
    key_ok    = (wr_data_i[KEY_LSB +: KEY_W] == KEY);
    good_wr   = wr_en_i & key_ok;
    bad_wr    = wr_en_i & ~key_ok;
    fire_o    = bad_wr | (timeout_i & ~good_wr);
    restart_o = good_wr;
    cfg_d     = good_wr ? wdg_cfg_t'(wr_data_i[CFG_W-1:0]) : cfg_q;
    cause_d   = fire_o ? 1'b1 : cause_q;
    if (bad_wr)      pwfail_d = 1'b1;
    else if (fire_o) pwfail_d = 1'b0;
    else             pwfail_d = pwfail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      cause_q  <= 1'b0;
      pwfail_q <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      cause_q  <= cause_d;
      pwfail_q <= pwfail_d;
    end
  end

  assign cfg_o    = cfg_q;
  assign cause_o  = cause_q;
  assign pwfail_o = pwfail_q;

  // R8: a wrong key leaves the configuration alone
  a_r8_bad_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !key_ok) |=> $stable(cfg_q));

  // R9: a wrong key raises both flags
  a_r9_bad_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !key_ok) |=> (pwfail_q && cause_q));

  // R10: the cause flag never falls outside reset
  a_r10_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q |=> cause_q);

endmodule

// File: rtl/wdg_action.sv
module wdg_action #(
  parameter int RST_HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic mode_i,
  output logic irq_o,
  output logic rst_req_o
);

  localparam int HOLD_W = $clog2(RST_HOLD + 1);

  logic              irq_q, irq_d;
  logic [HOLD_W-1:0] hold_q, hold_d;

  always_comb begin
    irq_d = fire_i & ~mode_i;
    if (fire_i && mode_i)    hold_d = HOLD_W'(RST_HOLD);
    else if (hold_q != '0)   hold_d = hold_q - HOLD_W'(1);
    else                     hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      irq_q  <= irq_d;
      hold_q <= hold_d;
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = (hold_q != '0);

  // R6: an interrupt only follows an interrupt-mode action
  a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(fire_i && !mode_i));

  // R7: the reset request only starts after a reset-mode action
  a_r7_req_source: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_o && !$past(rst_req_o)) |-> $past(fire_i && mode_i));

endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
  import wdg_pkg::*;
#(
  parameter int               CNT_W    = 12,
  parameter int               RST_HOLD = 16,
  parameter logic [KEY_W-1:0] KEY      = 8'h47
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        irq,
  output logic        rst_req
);

  localparam int DATA_W = 32;
  localparam int STAT_W = CFG_W + 2;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  wdg_cfg_t   cfg;
  logic       restart, fire, tick, ovf, cause, pwfail;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wdg_prescale u_prescale (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (restart),
    .sel_i  (cfg.sel),
    .tick_o (tick)
  );

  wdg_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (restart),
    .en_i   (cfg.en),
    .tick_i (tick),
    .ovf_o  (ovf)
  );

  wdg_access #(.KEY(KEY), .DATA_W(DATA_W)) u_access (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .timeout_i (ovf),
    .cfg_o     (cfg),
    .restart_o (restart),
    .fire_o    (fire),
    .cause_o   (cause),
    .pwfail_o  (pwfail)
  );

  wdg_action #(.RST_HOLD(RST_HOLD)) u_action (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .fire_i    (fire),
    .mode_i    (cfg.mode),
    .irq_o     (irq),
    .rst_req_o (rst_req)
  );

  assign rd_data = {{(DATA_W-STAT_W){1'b0}}, pwfail, cause, cfg};

  // R11: a correct-key write on an overflow edge suppresses the action
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_int_n)
    (restart && ovf) |=> (!irq && !$rose(rst_req)));

endmodule

// File: tb/wdg_guard_bench.sv
module wdg_guard_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 3;
  localparam int HOLD       = 4;
  localparam logic [7:0] KEY = 8'h47;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        irq, rst_req;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdg_guard #(.CNT_W(CNT_W), .RST_HOLD(HOLD), .KEY(KEY)) u_wdg_guard (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
  );

  function automatic int div_of(input int s);
    case (s)
      0: return 2;    1: return 4;    2: return 8;    3: return 64;
      4: return 128;  5: return 1024; 6: return 2048; default: return 4096;
    endcase
  endfunction

  function automatic logic [31:0] word(input logic m, input logic e,
                                       input logic [2:0] s, input logic [7:0] k);
    return {16'h0, k, 3'b000, m, e, s};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic do_write(input logic [31:0] v);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    int n, pulses, at, rises, highs, irqs;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 rd_data in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rd_data after reset", rd_data, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 rst_req after reset", {31'b0, rst_req}, 32'h0);

    // R4/R6 sweep over every divider select in interrupt mode
    for (int s = 0; s < 8; s++) begin
      int reps;
      reps = (s == 0) ? 2 : 1;
      n = (1 << CNT_W) * div_of(s);
      do_write(word(1'b0, 1'b1, 3'(s), KEY));
      chk($sformatf("R3 R2 readback sel %0d", s), rd_data,
          32'h08 | 32'(s) | ((s == 0) ? 32'h0 : 32'h20));
      pulses = 0; at = 0;
      for (int k = 1; k <= reps * n; k++) begin
        @(negedge clk);
        if (irq) begin pulses++; at = k; end
      end
      chk($sformatf("R4 last timeout cycle sel %0d", s), at, reps * n);
      chk($sformatf("R6 pulse count sel %0d", s), pulses, reps);
    end

    // R5 disabled
    do_write(word(1'b0, 1'b0, 3'd0, KEY));
    chk("R2 readback disabled", rd_data, 32'h20);
    pulses = 0;
    for (int k = 0; k < 64; k++) begin @(negedge clk); if (irq) pulses++; end
    chk("R5 no timeout while disabled", pulses, 0);

    // R8 bad key while disabled, interrupt mode
    do_write(word(1'b1, 1'b1, 3'd7, 8'h12));
    chk("R8 bad key fires irq", {31'b0, irq}, 32'h1);
    chk("R8 R9 cfg kept, flags set", rd_data, 32'h60);
    @(negedge clk);
    chk("R6 irq lasts one cycle", {31'b0, irq}, 32'h0);

    // R7 reset mode timeout
    do_write(word(1'b1, 1'b1, 3'd0, KEY));
    chk("R3 flags kept over good write", rd_data, 32'h78);
    rises = 0; highs = 0; irqs = 0; at = 0;
    for (int k = 1; k <= 16 + HOLD; k++) begin
      @(negedge clk);
      if (rst_req) begin highs++; if (at == 0) at = k; end
      if (irq) irqs++;
      if (k == 16) chk("R9 R10 flags while request high", rd_data, 32'h38);
    end
    chk("R7 request start cycle", at, 16);
    chk("R7 request length", highs, HOLD);
    chk("R7 no irq in reset mode", irqs, 0);
    chk("R10 flags after request", rd_data, 32'h38);

    // R8 bad key in reset mode
    do_write(word(1'b0, 1'b0, 3'd5, 8'h00));
    chk("R8 bad key raises request", {30'b0, irq, rst_req}, 32'h1);
    chk("R8 cfg unchanged in reset mode", rd_data, 32'h78);
    repeat (HOLD) @(negedge clk);
    chk("R7 request drops after hold", {31'b0, rst_req}, 32'h0);

    // R11 correct write on the overflow edge
    do_write(word(1'b0, 1'b1, 3'd0, KEY));
    repeat (15) @(negedge clk);
    do_write(word(1'b0, 1'b1, 3'd0, KEY));
    chk("R11 no action on collision", {30'b0, irq, rst_req}, 32'h0);
    chk("R11 flags untouched", rd_data, 32'h68);
    pulses = 0; at = 0;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (irq) begin pulses++; at = k; end
    end
    chk("R11 full new period", at, 16);
    chk("R11 single pulse", pulses, 1);

    // R9 timeout clears bad-key flag
    do_write(word(1'b1, 1'b0, 3'd3, 8'h48));
    chk("R8 bad key irq in interrupt mode", {31'b0, irq}, 32'h1);
    chk("R9 bad-key flag set", rd_data, 32'h68);
    do_write(word(1'b0, 1'b1, 3'd0, KEY));
    repeat (16) @(negedge clk);
    chk("R9 timeout irq", {31'b0, irq}, 32'h1);
    chk("R9 timeout clears bad-key flag", rd_data, 32'h28);

    // R10 only the external reset clears flags
    rst_n = 1'b0;
    #1;
    chk("R10 external reset clears", rd_data, 32'h0);
    chk("R1 outputs low in reset", {30'b0, irq, rst_req}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule